// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM refreshed on time while sharing the memory bus with a separate access controller. A free-running interval timer produces one refresh tick per required refresh slot. Each tick adds one unit of refresh debt. Each completed refresh cycle removes one unit. While the scheduler is idle and owes at least one refresh, it raises a request toward the access controller. The controller answers with a grant once the bus is free. After the handshake the scheduler owns the row strobe, the column strobe, the write strobe and the address bus until its cycle ends.

Two refresh styles are supported. In the column-first style, CAS is lowered while RAS is still high, and RAS then falls; no address is needed. In the row-address style, a row address is placed on the bus, RAS is pulsed low and CAS stays high. The row address comes from an internal counter that steps after every completed row-address refresh. Refreshes may be postponed while the bus is busy. Once the debt reaches a limit, an urgent flag tells the access controller to give refresh priority over pending accesses. All strobe timings are whole clock cycles, derived from nanosecond minimums and the clock rate. The refresh interval is derived from the refresh count, the refresh period and the clock rate.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, ras_n, cas_n and we_n are high, and ref_req, ref_busy, ref_urgent and addr_en are low.
- R2: The timer adds one debt unit every INTERVAL = PERIOD_MS*1000*CLK_MHZ/REFRESH_COUNT clock cycles. The first ref_req appears INTERVAL+1 rising edges after reset is released.
- R3: Debt saturates at twice URGENT_LIMIT, and a tick that arrives at the ceiling is lost. A tick and a completion on the same edge leave the debt unchanged.
- R4: ref_req is high exactly when the scheduler is idle and the debt is non-zero. Once high, it stays high until a cycle in which ref_gnt is also high. A refresh starts only on such a cycle. ref_gnt while ref_req is low has no effect.
- R5: ref_busy rises on the edge after the handshake and stays high for SETUP+RAS_CYC+PRE_CYC cycles. The debt drops by one on the edge that ends the cycle, and ref_req is never high while ref_busy is high.
- R6: ref_urgent is high whenever the debt is at least URGENT_LIMIT.
- R7: In column-first mode (mode_row_addr = 0), cas_n goes low for SETUP cycles while ras_n is high. Both strobes are then low for RAS_CYC cycles, and both are high for the precharge. addr_en stays low.
- R8: In row-address mode (mode_row_addr = 1), cas_n stays high. addr_en is high and addr carries the row count during the SETUP cycles and the RAS_CYC cycles that ras_n is low. addr is zero whenever addr_en is low.
- R9: The row count starts at 0 after reset and steps by one only when a row-address refresh completes. It wraps from 2^ROW_BITS-1 to 0.
- R10: mode_row_addr is sampled only on the handshake cycle. A change during a refresh affects only the next refresh.
- R11: ras_n is low for exactly RAS_CYC cycles per refresh. It then stays high for at least PRE_CYC = max(RP_CYC, RC_CYC-RAS_CYC) cycles before it can fall again.
- R12: we_n is held high at all times, so the column-first cycle never turns into a write-qualified entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_row_addr | input | 1 | 0: column-first refresh, 1: row-address refresh |
| ref_gnt | input | 1 | Bus free; accepts the pending request (ready) |
| ref_req | output | 1 | Refresh owed and scheduler idle (valid) |
| ref_urgent | output | 1 | Debt at or above URGENT_LIMIT |
| ref_busy | output | 1 | Scheduler owns the DRAM strobes and address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| addr_en | output | 1 | Scheduler drives the address bus |
| addr | output | ROW_BITS | Row address for row-address refresh |

## Verification
The bench withholds the grant for many intervals, so the debt climbs past the urgent limit into saturation. A ledger that wraps or keeps counting would then produce too many or too few back-to-back refreshes when the grant returns. It flips the mode in the middle of a refresh: a design that follows the live input would drop CAS partway through a row-address cycle, or drive an address during a column-first cycle. It runs enough row-address refreshes to wrap the row counter. A counter that steps on column-first cycles, or that steps at the wrong edge, shows up as a skipped or repeated row. It also measures every RAS low and high run, to catch an off-by-one in the phase counters.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_SETUP   = 2'd1,
    SQ_ROW_ACT = 2'd2,
    SQ_PRECHG  = 2'd3
  } seq_state_e;

  typedef enum logic {
    RM_CBR = 1'b0,
    RM_ROW = 1'b1
  } ref_mode_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ref_debt_ledger.sv
module ref_debt_ledger #(
  parameter int URGENT_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  output logic debt_nz,
  output logic urgent
);
  localparam int DEBT_MAX = 2 * URGENT_LIMIT;
  localparam int DW       = $clog2(DEBT_MAX + 1);
  localparam logic [DW-1:0] CEIL = DW'(DEBT_MAX);
  localparam logic [DW-1:0] LIM  = DW'(URGENT_LIMIT);

  logic [DW-1:0] debt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debt <= '0;
    end else if (tick && !done) begin
      if (debt != CEIL) debt <= debt + 1'b1;
    end else if (done && !tick) begin
      debt <= debt - 1'b1;
    end
  end

  assign debt_nz = (debt != '0);
  assign urgent  = (debt >= LIM);
endmodule

// File: rtl/ref_strobe_seq.sv
module ref_strobe_seq
  import dram_ref_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RAS_CYC   = 5,
  parameter int PRE_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic debt_nz,
  input  logic mode_in,
  input  logic gnt,
  output logic req,
  output logic done,
  output logic done_row,
  output logic busy,
  output logic ras_n,
  output logic cas_n,
  output logic row_drive
);
  localparam int MAXC = (SETUP_CYC > RAS_CYC) ?
                        ((SETUP_CYC > PRE_CYC) ? SETUP_CYC : PRE_CYC) :
                        ((RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

  seq_state_e    st, st_nx;
  ref_mode_e     md_q, md_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          in_cyc_nx;

  assign req = (st == SQ_IDLE) && debt_nz;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    md_nx  = md_q;
    done   = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        if (req && gnt) begin
          st_nx  = SQ_SETUP;
          cnt_nx = CW'(SETUP_CYC - 1);
          md_nx  = ref_mode_e'(mode_in);
        end
      end
      SQ_SETUP: begin
        if (cnt == '0) begin
          st_nx  = SQ_ROW_ACT;
          cnt_nx = CW'(RAS_CYC - 1);
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      SQ_ROW_ACT: begin
        if (cnt == '0) begin
          st_nx  = SQ_PRECHG;
          cnt_nx = CW'(PRE_CYC - 1);
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      SQ_PRECHG: begin
        if (cnt == '0) begin
          st_nx = SQ_IDLE;
          done  = 1'b1;
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      default: st_nx = SQ_IDLE;
    endcase
  end

  assign done_row  = done && (md_q == RM_ROW);
  assign in_cyc_nx = (st_nx == SQ_SETUP) || (st_nx == SQ_ROW_ACT);

  // Strobes come straight from flops so the DRAM pins never see decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      cnt       <= '0;
      md_q      <= RM_CBR;
      busy      <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      row_drive <= 1'b0;
    end else begin
      st        <= st_nx;
      cnt       <= cnt_nx;
      md_q      <= md_nx;
      busy      <= (st_nx != SQ_IDLE);
      ras_n     <= (st_nx != SQ_ROW_ACT);
      cas_n     <= !(in_cyc_nx && (md_nx == RM_CBR));
      row_drive <= in_cyc_nx && (md_nx == RM_ROW);
    end
  end
endmodule

// File: rtl/ras_row_counter.sv
module ras_row_counter #(
  parameter int ROW_BITS = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [ROW_BITS-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ       = 100,
  parameter int REFRESH_COUNT = 8192,
  parameter int PERIOD_MS     = 128,
  parameter int ROW_BITS      = 13,
  parameter int URGENT_LIMIT  = 8,
  parameter int T_RAS_NS      = 50,
  parameter int T_RP_NS       = 30,
  parameter int T_RC_NS       = 84,
  parameter int T_SETUP_NS    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_row_addr,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                ref_urgent,
  output logic                ref_busy,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                addr_en,
  output logic [ROW_BITS-1:0] addr
);
  localparam int INTERVAL  = (PERIOD_MS * 1000 * CLK_MHZ) / REFRESH_COUNT;
  localparam int RAS_CYC   = ns_to_cyc(T_RAS_NS, CLK_MHZ);
  localparam int RP_CYC    = ns_to_cyc(T_RP_NS, CLK_MHZ);
  localparam int RC_CYC    = ns_to_cyc(T_RC_NS, CLK_MHZ);
  localparam int SETUP_CYC = ns_to_cyc(T_SETUP_NS, CLK_MHZ);
  localparam int PRE_CYC   = (RC_CYC - RAS_CYC > RP_CYC) ? (RC_CYC - RAS_CYC) : RP_CYC;

  logic                tick, debt_nz, done, done_row, row_drive;
  logic [ROW_BITS-1:0] row;

  ref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ref_debt_ledger #(.URGENT_LIMIT(URGENT_LIMIT)) u_ledger (
    .clk(clk), .rst_n(rst_n), .tick(tick), .done(done),
    .debt_nz(debt_nz), .urgent(ref_urgent)
  );

  ref_strobe_seq #(
    .SETUP_CYC(SETUP_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .debt_nz(debt_nz), .mode_in(mode_row_addr),
    .gnt(ref_gnt), .req(ref_req), .done(done), .done_row(done_row),
    .busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n), .row_drive(row_drive)
  );

  ras_row_counter #(.ROW_BITS(ROW_BITS)) u_rows (
    .clk(clk), .rst_n(rst_n), .adv(done_row), .row(row)
  );

  assign we_n    = 1'b1;
  assign addr_en = row_drive;
  assign addr    = row_drive ? row : '0;
endmodule

// File: rtl/ref_sched_checker.sv
module ref_sched_checker
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int T_RAS_NS = 50
) (
  input logic clk,
  input logic rst_n,
  input logic ref_req,
  input logic ref_gnt,
  input logic ref_busy,
  input logic ref_urgent,
  input logic ras_n,
  input logic cas_n,
  input logic addr_en
);
  localparam int RAS_CYC = ns_to_cyc(T_RAS_NS, CLK_MHZ);

  logic [15:0] lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lo_cnt <= '0;
    else if (ras_n)          lo_cnt <= '0;
    else if (lo_cnt != '1)   lo_cnt <= lo_cnt + 1'b1;
  end

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);

  assert_handshake_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> ref_busy);

  assert_no_req_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !ref_req);

  assert_urgent_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> (ref_req || ref_busy));

  assert_cas_leads_ras_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  assert_cas_high_row_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> cas_n);

  assert_ras_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt == 16'(RAS_CYC)));
endmodule

bind dram_refresh_sched ref_sched_checker #(
  .CLK_MHZ(CLK_MHZ), .T_RAS_NS(T_RAS_NS)
) u_ref_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
  .ref_busy(ref_busy), .ref_urgent(ref_urgent), .ras_n(ras_n),
  .cas_n(cas_n), .addr_en(addr_en)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWB  = 3;
  localparam int ROWS  = 8;
  localparam int IVL   = 24;   // 1 ms * 1000 * 100 MHz / 4096
  localparam int SET_C = 1;    // 5 ns at 100 MHz
  localparam int RAS_C = 5;    // 50 ns
  localparam int PRE_C = 4;    // max(30 ns -> 3, 84 ns -> 9 minus 5)
  localparam int LIM   = 8;
  localparam int DMAX  = 16;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, gnt = 1'b0;
  logic ref_req, ref_urgent, ref_busy, ras_n, cas_n, we_n, addr_en;
  logic [ROWB-1:0] addr;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_sched #(
    .CLK_MHZ(100), .REFRESH_COUNT(4096), .PERIOD_MS(1),
    .ROW_BITS(ROWB), .URGENT_LIMIT(LIM)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .mode_row_addr(mode), .ref_gnt(gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_busy(ref_busy),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_en(addr_en), .addr(addr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Behavioural reference: phase 0 idle, 1 setup, 2 RAS low, 3 precharge.
  int m_ph = 0, m_rem = 0, m_debt = 0, m_tcnt = 0, m_row = 0, m_md = 0;
  bit m_tick = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_debt = 0; m_tcnt = 0; m_row = 0; m_md = 0; m_tick = 0;
    end else begin
      bit inc, fin, take;
      inc  = m_tick;
      fin  = (m_ph == 3) && (m_rem == 0);
      take = (m_ph == 0) && (m_debt > 0) && gnt;
      if (inc && !fin) m_debt = (m_debt < DMAX) ? m_debt + 1 : m_debt;
      else if (fin && !inc) m_debt = m_debt - 1;
      m_tick = (m_tcnt == IVL - 1);
      m_tcnt = (m_tcnt + 1) % IVL;
      if (fin && m_md == 1) m_row = (m_row + 1) % ROWS;
      case (m_ph)
        0: if (take) begin m_ph = 1; m_rem = SET_C - 1; m_md = mode; end
        1: if (m_rem == 0) begin m_ph = 2; m_rem = RAS_C - 1; end else m_rem--;
        2: if (m_rem == 0) begin m_ph = 3; m_rem = PRE_C - 1; end else m_rem--;
        default: if (m_rem == 0) m_ph = 0; else m_rem--;
      endcase
    end
  end

  // Per-clock comparison against the reference.
  always @(negedge clk) begin
    if (cmp_en) begin
      bit e_req, e_urg, e_busy, e_ras, e_cas, e_aen;
      int e_addr;
      e_req  = (m_ph == 0) && (m_debt > 0);
      e_urg  = (m_debt >= LIM);
      e_busy = (m_ph != 0);
      e_ras  = (m_ph != 2);
      e_cas  = !((m_ph == 1 || m_ph == 2) && m_md == 0);
      e_aen  = (m_ph == 1 || m_ph == 2) && m_md == 1;
      e_addr = e_aen ? m_row : 0;
      check(ref_req == e_req,   "R4/R2 ref_req", ref_req, e_req);
      check(ref_urgent == e_urg, "R6/R3 ref_urgent", ref_urgent, e_urg);
      check(ref_busy == e_busy, "R5 ref_busy", ref_busy, e_busy);
      check(ras_n == e_ras,     "R7/R11 ras_n", ras_n, e_ras);
      check(cas_n == e_cas,     "R7/R10 cas_n", cas_n, e_cas);
      check(addr_en == e_aen,   "R8/R10 addr_en", addr_en, e_aen);
      check(int'(addr) == e_addr, "R9 addr", addr, e_addr);
      check(we_n == 1'b1,       "R12 we_n", we_n, 1);
    end
  end

  // Pulse-width and ordering monitor, independent of the reference phases.
  logic p_ras = 1'b1, p_cas = 1'b1;
  int lo_run = 0, hi_run = 0, exp_row = 0;
  bit seen_low = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      if (!ras_n) lo_run++;
      else hi_run++;
      if (p_ras && !ras_n) begin
        if (seen_low) check(hi_run - 0 >= PRE_C, "R11 precharge run", hi_run, PRE_C);
        if (m_md == 0) begin
          check(!p_cas && !cas_n, "R7 CAS before RAS", p_cas, 0);
        end else begin
          check(cas_n && addr_en && int'(addr) == exp_row, "R9 row sequence", addr, exp_row);
          exp_row = (exp_row + 1) % ROWS;
        end
        lo_run = 1; seen_low = 1;
      end
      if (!p_ras && ras_n) begin
        check(lo_run == RAS_C, "R11 RAS low run", lo_run, RAS_C);
        hi_run = 1;
      end
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    int n, refs;
    bit idle_hold;
    repeat (4) @(negedge clk);
    // R1: outputs during reset.
    check(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
    check(!ref_req && !ref_busy && !ref_urgent && !addr_en, "R1 control in reset",
          {ref_req, ref_busy, ref_urgent, addr_en}, 0);
    gnt = 1'b1;
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // R2: first request timing.
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_req && n < 200);
    check(n == IVL + 1, "R2 first request edge", n, IVL + 1);

    // Column-first refreshes with the grant always available (R7).
    repeat (200) @(negedge clk);

    // Row-address refreshes across a counter wrap (R8, R9).
    mode = 1'b1;
    repeat (300) @(negedge clk);

    // R10: flip mode in the middle of a refresh.
    while (!ref_busy) @(negedge clk);
    mode = 1'b0;
    @(negedge clk);
    check(cas_n && addr_en, "R10 latched row mode kept", cas_n, 1);
    while (ref_busy) @(negedge clk);
    repeat (60) @(negedge clk);
    mode = 1'b1;
    repeat (60) @(negedge clk);

    // R4, R6, R3: withhold the grant long enough to saturate the debt.
    while (ref_busy) @(negedge clk);
    gnt = 1'b0;
    idle_hold = 1;
    repeat (30 * IVL) begin
      @(negedge clk);
      if (ref_busy) idle_hold = 0;
    end
    check(idle_hold, "R4 no refresh without grant", !idle_hold, 0);
    check(ref_urgent && ref_req, "R6 urgent after postponement", ref_urgent, 1);

    gnt = 1'b1;
    refs = 0; n = 0;
    while (ref_req || ref_busy) begin
      @(negedge clk);
      n++;
      if (ref_busy && p_ras && !ras_n) refs++;
      if (n > 2000) break;
    end
    check(refs >= DMAX && refs <= DMAX + n / IVL + 1, "R3 saturated debt drained", refs, DMAX);

    // R4: grant with nothing owed has no effect.
    @(negedge clk);
    check(!ref_busy && ras_n, "R4 idle grant ignored", ref_busy, 0);
    repeat (100) @(negedge clk);
    finish_run();
  end
endmodule